// File: doc/BRIEF.md
# Symmetric Glitch-Rejecting Command Filter

This block cleans up a bank of single-bit command lines before they reach gate-drive logic. Each line gets its own filter. A level change on a line reaches the output only after the new level has been seen for a set number of consecutive clock samples. Any excursion shorter than that, whether a high spike on a low line or a low dip on a high line, leaves the output as it was.

A plain debouncer lets its output follow a change as soon as it qualifies. Shortened pulses come from filters whose release delay differs from their assert delay. This filter adds the same latency to both edges, so an accepted pulse comes out exactly as wide as it went in. Pulses only just long enough to qualify keep their width too.

The inputs are expected to be synchronised upstream. Because the command lines are active low, the filtered outputs come out of reset at logic high.

Top module: `glitch_sym_filter`

## Requirements
- R1: While reset is asserted and on the first cycles after it, every output bit is 1, whatever the inputs are.
- R2: When a line has been sampled at the level opposite to its output for FILT_CYCLES consecutive clock edges, the output takes that level. It changes on the same edge that takes the FILT_CYCLES-th sample. The default FILT_CYCLES is 8.
- R3: A low excursion lasting fewer than FILT_CYCLES samples on a line whose output is 1 leaves the output at 1.
- R4: A high excursion lasting fewer than FILT_CYCLES samples on a line whose output is 0 leaves the output at 0.
- R5: An input pulse of W samples, with W at least FILT_CYCLES, produces an output pulse of exactly W cycles. Both edges of the output pulse lag the input by FILT_CYCLES-1 cycles after the sampling edge.
- R6: A pulse of exactly FILT_CYCLES samples passes with width FILT_CYCLES. A pulse of FILT_CYCLES-1 samples is removed.
- R7: Each line is filtered independently. Bit i of the output depends only on bit i of the input.
- R8: If a qualifying excursion is broken by even one sample of the old level, qualification restarts from the next sample at the new level.
- R9: Back-to-back accepted pulses, with highs and lows each at least FILT_CYCLES samples long, keep every width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | CHANNELS | Raw synchronised command lines |
| dout | output | CHANNELS | Filtered command lines, reset value all ones |

## Verification
The per-line state is an accepted level plus a qualification count. A count that does not clear on a broken excursion shows up at the output as an early change, within at most FILT_CYCLES cycles of the broken glitch. A count that runs off by one moves both output edges by a cycle, and the next accepted edge shows it. A wrong accepted level shows as an output that disagrees with an input held steady for FILT_CYCLES samples. The bench compares the output on every cycle against an independent model, so any of these faults is caught on the first cycle it appears.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
    typedef enum logic {
        LINE_SETTLED = 1'b0,
        LINE_QUALIFY = 1'b1
    } line_phase_e;
endpackage

// File: rtl/glitch_line.sv
module glitch_line #(
    parameter int  FILT_CYCLES = 8,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    import glitch_filter_pkg::*;

    localparam int CNT_W = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FILT_CYCLES - 1);

    typedef struct packed {
        line_phase_e      phase;
        logic             level;
        logic [CNT_W-1:0] cnt;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            LINE_SETTLED: begin
                if (din != st_q.level) begin
                    st_d.phase = LINE_QUALIFY;
                    st_d.cnt   = CNT_W'(1);
                end
            end
            LINE_QUALIFY: begin
                if (din == st_q.level) begin
                    // excursion broken: discard the pending edge
                    st_d.phase = LINE_SETTLED;
                    st_d.cnt   = '0;
                end else if (st_q.cnt == LAST_CNT) begin
                    st_d.phase = LINE_SETTLED;
                    st_d.level = din;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= LINE_SETTLED;
            st_q.level <= IDLE_LEVEL;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.level;
endmodule

// File: rtl/glitch_sym_filter.sv
module glitch_sym_filter #(
    parameter int CHANNELS    = 6,
    parameter int FILT_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] din,
    output logic [CHANNELS-1:0] dout
);
    generate
        for (genvar gi = 0; gi < CHANNELS; gi++) begin : g_line
            glitch_line #(
                .FILT_CYCLES(FILT_CYCLES),
                .IDLE_LEVEL (1'b1)
            ) u_line (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (din[gi]),
                .dout (dout[gi])
            );
        end
    endgenerate
endmodule

// File: rtl/glitch_sym_filter_chk.sv
module glitch_sym_filter_chk #(
    parameter int CHANNELS    = 6,
    parameter int FILT_CYCLES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CHANNELS-1:0] din,
    input logic [CHANNELS-1:0] dout
);
    localparam int RUN_W = $clog2(FILT_CYCLES + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(FILT_CYCLES + 1);
    localparam logic [RUN_W-1:0] RUN_N   = RUN_W'(FILT_CYCLES);

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_RESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> dout == {CHANNELS{1'b1}}); // R1

    generate
        for (genvar gi = 0; gi < CHANNELS; gi++) begin : g_chk
            logic [RUN_W-1:0] run_q;
            logic             last_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q  <= '0;
                    last_q <= 1'b1;
                end else begin
                    last_q <= din[gi];
                    if (run_q != '0 && din[gi] == last_q) begin
                        if (run_q != RUN_SAT) run_q <= run_q + RUN_W'(1);
                    end else begin
                        run_q <= RUN_W'(1);
                    end
                end
            end

            AST_QUALIFIED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
                dout[gi] != $past(dout[gi]) |-> run_q == RUN_N); // R2

            AST_CHANGE_TOWARD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
                dout[gi] != $past(dout[gi]) |-> dout[gi] == last_q); // R3

            AST_SETTLED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
                run_q >= RUN_N |-> dout[gi] == last_q); // R5
        end
    endgenerate
endmodule

bind glitch_sym_filter glitch_sym_filter_chk #(
    .CHANNELS   (CHANNELS),
    .FILT_CYCLES(FILT_CYCLES)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .dout (dout)
);

// File: tb/glitch_sym_filter_bench.sv
module glitch_sym_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 6;
    localparam int N  = 8;

    typedef struct {
        logic [CH-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] din = '0;
    logic [CH-1:0] dout;

    int checks = 0;
    int fails  = 0;
    item_t q[$];
    int m_run [CH];
    logic m_out [CH];
    bit done = 0;

    glitch_sym_filter #(.CHANNELS(CH), .FILT_CYCLES(N)) u_glitch_sym_filter (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply a vector for some cycles, predict the output after each sampling edge
    task automatic hold(input logic [CH-1:0] v, input int cycles, input string tag);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            din = v;
            for (int c = 0; c < CH; c++) begin
                if (v[c] != m_out[c]) begin
                    m_run[c]++;
                    if (m_run[c] == N) begin
                        m_out[c] = v[c];
                        m_run[c] = 0;
                    end
                end else begin
                    m_run[c] = 0;
                end
            end
            begin
                item_t it;
                for (int c = 0; c < CH; c++) it.exp[c] = m_out[c];
                it.tag = tag;
                q.push_back(it);
            end
        end
    endtask

    function automatic logic [CH-1:0] low_on(input int c);
        logic [CH-1:0] v;
        v = '1;
        v[c] = 1'b0;
        return v;
    endfunction

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (dout !== it.exp) begin
                    fails++;
                    $display("FAIL %s: dout=%b expected=%b", it.tag, dout, it.exp);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < CH; c++) begin
            m_run[c] = 0;
            m_out[c] = 1'b1;
        end
        // R1: inputs low during reset must not move the outputs
        repeat (4) @(negedge clk);
        checks++;
        if (dout !== '1) begin
            fails++;
            $display("FAIL R1: dout=%b expected=%b", dout, {CH{1'b1}});
        end
        din = '1;
        rst_n = 1'b1;
        hold('1, 4, "R1");
        // R3: short low dips on line 0 while high
        hold(low_on(0), 3, "R3");
        hold('1, 10, "R3");
        hold(low_on(0), N-1, "R6");
        hold('1, 12, "R6");
        // R6 / R2: exactly N samples passes
        hold(low_on(0), N, "R2");
        hold('1, 14, "R6");
        // R5: longer pulse keeps width
        hold(low_on(1), 20, "R5");
        hold('1, 22, "R5");
        // R4: high spikes on line 2 while its output is low
        hold(low_on(2), 20, "R4");
        hold('1, 2, "R4");
        hold(low_on(2), 10, "R4");
        hold('1, N-1, "R4");
        hold(low_on(2), 10, "R4");
        hold('1, 20, "R4");
        // R8: broken qualification restarts
        hold(low_on(3), 5, "R8");
        hold('1, 1, "R8");
        hold(low_on(3), N-1, "R8");
        hold(low_on(3), 1, "R8");
        hold('1, 20, "R8");
        // R7: line 4 held low while line 5 toggles every cycle
        for (int k = 0; k < 16; k++) begin
            logic [CH-1:0] v;
            v = low_on(4);
            v[5] = k[0];
            hold(v, 1, "R7");
        end
        hold('1, 20, "R7");
        // R9: back-to-back pulses on line 0
        hold(low_on(0), 10, "R9");
        hold('1, N, "R9");
        hold(low_on(0), 9, "R9");
        hold('1, N+1, "R9");
        hold(low_on(0), N, "R9");
        hold('1, 20, "R9");
        // R3 on all lines at once
        hold('0, N-1, "R3");
        hold('1, 12, "R3");
        @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule